// File: doc/BRIEF.md
# PCM Audio Sample Streamer

The streamer turns a mono stream of 8-bit unsigned PCM samples into a stereo I2S bit stream for an HDMI audio path. A host pushes samples, one per cycle, through a write strobe into a small on-chip FIFO. A rate divider fires once per sample period (32 kHz by default), and each firing pops one sample. The sample is converted to two's complement, placed at the top of a wider word, and transmitted in both the left and right slots of one I2S frame.

The host watches the level output and tops up the FIFO before it runs dry. If a sample period arrives while the FIFO is empty, the frame carries digital silence instead, and a sticky flag records the underrun. The flag stays set until the host pulses a clear strobe.

Top module: `pcm_i2s_streamer`

## Requirements
- R1: After a synchronous active-high reset, the bit clock, word select and data outputs are 0, the level is 0 and the underrun flag is 0.
- R2: One sample is consumed every CLK_HZ/RATE_HZ system cycles, so successive frames start exactly that many cycles apart and each pop lowers the level by one.
- R3: An 8-bit sample s is sent as the WORD_W-bit word {~s[7], s[6:0], zeros}, which means the sample's MSB is inverted and the sample is left-justified.
- R4: Every frame carries the same word in both slots. The left slot is sent while word select is 0, and the right slot while it is 1.
- R5: Data is sent MSB first. The first bit of a slot comes one bit clock after the word-select change, and each slot spans WORD_W bit-clock rising edges. Word select and data change only together with a falling bit-clock edge, so both are stable across every rising edge.
- R6: When a sample period finds the FIFO empty, both slots of that frame carry the all-zero word (mid-scale silence) and the underrun flag is set.
- R7: The underrun flag stays set until a one-cycle clear strobe is applied, and it reads 0 on the cycle after the clear. A new underrun in the same cycle as a clear leaves the flag set.
- R8: A write while the FIFO holds FIFO_DEPTH samples is dropped, and the level stays at FIFO_DEPTH.
- R9: The level output equals the number of samples held.
- R10: Samples are played in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Sample write strobe |
| wr_data_i | input | SAMPLE_W | Unsigned PCM sample to store |
| clr_underrun_i | input | 1 | Clears the underrun flag |
| level_o | output | $clog2(FIFO_DEPTH+1) | Samples held in the FIFO |
| underrun_o | output | 1 | Sticky underrun flag |
| i2s_bclk_o | output | 1 | I2S bit clock |
| i2s_ws_o | output | 1 | I2S word select, 0 for the left slot |
| i2s_sd_o | output | 1 | I2S serial data |

## Verification
A FIFO pointer or count fault appears at the ports within one sample period, as a wrong or repeated word in the next frame or as a level value that does not match the writes and pops. A slip in the serializer counter moves the word-select edge or the data alignment within the same frame, so the reassembled slot word is wrong or the slot no longer spans exactly WORD_W rising edges. A fault in the rate divider shows as a gap between frame starts that differs from CLK_HZ/RATE_HZ cycles. A fault in the underrun logic shows at the first empty period, as a silent frame with the flag still clear, or as a flag that drops without a clear.

// File: rtl/pcm_stream_pkg.sv
package pcm_stream_pkg;
  typedef enum logic {
    FEED_IDLE = 1'b0,
    FEED_LOAD = 1'b1
  } feed_state_t;
endpackage

// File: rtl/pcm_rate_tick.sv
module pcm_rate_tick #(
  parameter int DIV = 3906
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (cnt_q == CW'(DIV - 1)) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: a sample tick lasts one cycle only
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       rd_en_i,
  output logic [DW-1:0]              rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          full, do_wr, do_rd;

  assign full  = (count_o == LW'(DEPTH));
  assign do_wr = wr_en_i && !full;
  assign do_rd = rd_en_i && (count_o != '0);

  // memory write and registered read, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data_i;
    if (do_rd) rd_data_o <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R8: a write to a full FIFO without a pop leaves the level at depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (count_o == LW'(DEPTH)) && wr_en_i && !rd_en_i |=> count_o == LW'(DEPTH));
  // R6: the reader never pops an empty FIFO
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |-> count_o != '0);
endmodule

// File: rtl/pcm_i2s_tx.sv
module pcm_i2s_tx #(
  parameter int WORD_W    = 16,
  parameter int BCLK_HALF = 61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sd_o
);
  localparam int SW    = $clog2(WORD_W);
  localparam int NHALF = 4 * WORD_W;
  localparam int IW    = $clog2(NHALF);
  localparam int HCW   = $clog2(BCLK_HALF + 1);

  logic [WORD_W-1:0] word_q;
  logic              last_lsb_q;
  logic              active_q;
  logic [HCW-1:0]    half_cnt_q;
  logic [IW-1:0]     hidx_q;
  logic [SW-1:0]     pos;
  logic              slot_sel;
  logic              bit_val;

  // hidx bit 0 is the bit-clock phase, bits SW:1 the position in a slot,
  // bit SW+1 the slot (word select)
  assign pos      = hidx_q[SW:1];
  assign slot_sel = hidx_q[SW+1];

  always_comb begin
    if (pos == '0) begin
      bit_val = slot_sel ? word_q[0] : last_lsb_q;
    end else begin
      bit_val = word_q[WORD_W - int'(pos)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      last_lsb_q <= 1'b0;
      active_q   <= 1'b0;
      half_cnt_q <= '0;
      hidx_q     <= '0;
      bclk_o     <= 1'b0;
      ws_o       <= 1'b0;
      sd_o       <= 1'b0;
    end else begin
      if (active_q) begin
        bclk_o <= hidx_q[0];
        ws_o   <= slot_sel;
        sd_o   <= bit_val;
        if (half_cnt_q == HCW'(BCLK_HALF - 1)) begin
          half_cnt_q <= '0;
          hidx_q     <= hidx_q + 1'b1;
          if (hidx_q == IW'(NHALF - 1)) active_q <= 1'b0;
        end else begin
          half_cnt_q <= half_cnt_q + 1'b1;
        end
      end else begin
        bclk_o <= 1'b0;
      end
      if (load_i) begin
        word_q     <= word_i;
        last_lsb_q <= word_q[0];
        active_q   <= 1'b1;
        half_cnt_q <= '0;
        hidx_q     <= '0;
      end
    end
  end

  // R5: word select and data move only while the bit clock is low
  p_ws_on_low_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws_o) |-> !bclk_o);
  p_sd_on_low_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_o) |-> !bclk_o);
endmodule

// File: rtl/pcm_i2s_streamer.sv
module pcm_i2s_streamer #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int RATE_HZ    = 32_000,
  parameter int SAMPLE_W   = 8,
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic [SAMPLE_W-1:0]             wr_data_i,
  input  logic                            clr_underrun_i,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] level_o,
  output logic                            underrun_o,
  output logic                            i2s_bclk_o,
  output logic                            i2s_ws_o,
  output logic                            i2s_sd_o
);
  import pcm_stream_pkg::*;

  localparam int TICK_DIV  = CLK_HZ / RATE_HZ;
  localparam int BCLK_HALF = TICK_DIV / (4 * WORD_W);
  localparam int PAD_W     = WORD_W - SAMPLE_W;

  logic                tick;
  logic                rd_en;
  logic [SAMPLE_W-1:0] rd_data;
  logic                fetched_q;
  logic                load;
  logic [WORD_W-1:0]   word;
  feed_state_t         state_q;

  pcm_rate_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  pcm_sample_fifo #(.DW(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .count_o   (level_o)
  );

  assign rd_en = tick && (level_o != '0);

  // feed FSM: the tick pops a sample, and the next cycle loads the serializer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FEED_IDLE;
      fetched_q  <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      case (state_q)
        FEED_IDLE: if (tick) begin
          state_q   <= FEED_LOAD;
          fetched_q <= rd_en;
        end
        FEED_LOAD: state_q <= FEED_IDLE;
        default:   state_q <= FEED_IDLE;
      endcase
      if (tick && (level_o == '0)) underrun_o <= 1'b1;
      else if (clr_underrun_i)     underrun_o <= 1'b0;
    end
  end

  assign load = (state_q == FEED_LOAD);
  assign word = fetched_q ? {~rd_data[SAMPLE_W-1], rd_data[SAMPLE_W-2:0], {PAD_W{1'b0}}}
                          : '0;

  pcm_i2s_tx #(.WORD_W(WORD_W), .BCLK_HALF(BCLK_HALF)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .word_i (word),
    .bclk_o (i2s_bclk_o),
    .ws_o   (i2s_ws_o),
    .sd_o   (i2s_sd_o)
  );

  // R7: the flag holds until a clear arrives
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    underrun_o && !clr_underrun_i |=> underrun_o);
  // R6: a sample period on an empty FIFO raises the flag
  p_underrun_set_r6: assert property (@(posedge clk) disable iff (rst)
    tick && (level_o == '0) |=> underrun_o);
endmodule

// File: tb/pcm_i2s_streamer_tb.sv
module pcm_i2s_streamer_tb;
  localparam int CLK_HZ = 6400;
  localparam int RATE_HZ = 100;
  localparam int PERIOD = CLK_HZ / RATE_HZ;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          clr = 1'b0;
  logic [LW-1:0] level;
  logic          underrun, bclk, ws, sd;

  int checks = 0;
  int fails = 0;
  int lw_count = 0;
  int cyc = 0;
  logic [7:0] model[$];

  always #4 clk = ~clk;

  pcm_i2s_streamer #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ), .SAMPLE_W(8),
                     .WORD_W(16), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .clr_underrun_i(clr), .level_o(level), .underrun_o(underrun),
    .i2s_bclk_o(bclk), .i2s_ws_o(ws), .i2s_sd_o(sd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_burst(input logic [7:0] vals[]);
    foreach (vals[i]) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = vals[i];
      if (model.size() < DEPTH) model.push_back(vals[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: rebuilds slot words from the bit stream and scores them
  logic        p_bclk = 0, p_ws = 0, p_sd = 0, ws_at_rise = 0;
  logic [15:0] sr = '0, exp_word = '0;
  int          rises = 0, last_left = -1;
  bit          seen_trans = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!p_bclk && bclk) begin
        check(ws == p_ws && sd == p_sd, "R5 stable across rise", {ws, sd}, {p_ws, p_sd});
        sr = {sr[14:0], sd};
        rises++;
        if (ws != ws_at_rise) begin
          if (seen_trans) check(rises == 16, "R5 slot length", rises, 16);
          seen_trans = 1;
          rises = 0;
          if (ws) begin
            if (model.size() > 0) begin
              logic [7:0] s;
              s = model.pop_front();
              exp_word = {~s[7], s[6:0], 8'h00};
              check(sr == exp_word, "R3 R10 left word", sr, exp_word);
            end else begin
              exp_word = '0;
              check(sr == 16'h0000, "R6 silence word", sr, 0);
              check(underrun == 1'b1, "R6 flag set", underrun, 1);
            end
            if (last_left >= 0) check(cyc - last_left == PERIOD, "R2 frame spacing", cyc - last_left, PERIOD);
            last_left = cyc;
            lw_count++;
          end else begin
            check(sr == exp_word, "R4 right equals left", sr, exp_word);
          end
        end
        ws_at_rise = ws;
      end
      p_bclk = bclk; p_ws = ws; p_sd = sd;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(bclk == 0, "R1 bclk", bclk, 0);
    check(ws == 0, "R1 ws", ws, 0);
    check(sd == 0, "R1 sd", sd, 0);
    check(level == 0, "R1 level", level, 0);
    check(underrun == 0, "R1 flag", underrun, 0);

    wait (lw_count >= 2);
    @(negedge clk);
    check(underrun == 1, "R7 sticky", underrun, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check(underrun == 0, "R7 cleared", underrun, 0);

    n = lw_count;
    write_burst('{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hA5, 8'h5A, 8'hC3, 8'h11, 8'h22});
    check(level == DEPTH, "R8 R9 level full", level, DEPTH);
    wait (lw_count == n + 1);
    @(negedge clk);
    check(level == DEPTH - 1, "R2 R9 level after pop", level, DEPTH - 1);

    wait (lw_count == n + 9);
    @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check(underrun == 0, "R7 cleared again", underrun, 0);

    for (int i = 0; i < 5; i++) begin
      n = lw_count;
      wait (lw_count == n + 1);
      write_burst('{8'(8'h30 + 8'(i * 37))});
      check(level == 1, "R9 level one", level, 1);
    end
    n = lw_count;
    wait (lw_count == n + 3);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule